// File: doc/BRIEF.md
# Configurable Storage-Element Bank

This block is a group of eight one-bit storage elements that share a single clock, a single clock enable and a single set/reset input. One configuration word decides how the whole group behaves. A few site-wide bits pick the set/reset timing style, flip-flop or latch operation, clock polarity, and whether the enable and the set/reset inputs take effect at all. Per-element bits pick the value each element loads on set/reset and the value it loads on global initialisation.

The elements come in two rows. Elements 0..3 form the primary row and elements 4..7 form the secondary row. In flip-flop mode all eight elements are edge-triggered flip-flops. In latch mode the primary row becomes level-sensitive latches and the secondary row is unavailable: each secondary output sits at its initialisation value. A global set/reset pulse has the highest priority and forces every element to its initialisation value at once, in every mode.

The configuration word is 29 bits wide. Bits 4..0 are the site bits. Bits 12..5 are the element class bits. Bits 20..13 are the reset-value bits. Bits 28..21 are the init bits. Change the configuration only while the global set/reset is held, and hold it across at least one clock edge after the change.

Top module: `slice_store_bank`

## Requirements
- R1: Site bit cfg[0] selects the set/reset timing in flip-flop mode. With 0, an asserted, enabled set/reset changes the flip-flop outputs at once, without waiting for a clock edge. With 1, it takes effect only at the active clock edge.
- R2: With site bit cfg[1] = 1 (latch mode), elements 0..3 are latches. Each is transparent while the internal gate is high and holds its value while the gate is low. In latch mode set/reset always acts at once, whatever cfg[0] holds.
- R3: In latch mode, outputs 4..7 equal their initialisation value and do not respond to their data inputs, to the enable or to set/reset.
- R4: The set/reset load value of element i is given by its class bit cfg[5+i] and its reset-value bit cfg[13+i]. For class 0 the load value is the inverse of the reset-value bit. For class 1 it equals the reset-value bit.
- R5: While gsr is high, element i shows its init value at once. In flip-flop mode that value is the inverse of cfg[21+i]. In latch mode it equals cfg[21+i].
- R6: With cfg[3] = 0 the enable input is ignored and the elements capture data on every active edge or gate phase. With cfg[3] = 1 they capture only while ce is 1 and hold otherwise.
- R7: With cfg[4] = 0 the sr input has no effect. With cfg[4] = 1 an asserted sr loads the R4 values.
- R8: The internal gate equals clk XOR cfg[2] XOR cfg[1]. Flip-flops capture on its rising edge. So flip-flop mode with cfg[2] = 0 captures on the rising clk edge, and latch mode with cfg[2] = 0 is transparent while clk is low.
- R9: Priority runs from gsr, to sr (when enabled by R7), to the enable. An active sr overrides the enable in both timing styles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock; polarity is set by R8 |
| ce | input | 1 | Shared capture enable, active high |
| sr | input | 1 | Shared set/reset, active high |
| gsr | input | 1 | Global initialisation, active high, asynchronous |
| d | input | 8 | One data input per element |
| cfg | input | 29 | Configuration word (site bits, class, reset-value and init bits) |
| q | output | 8 | One stored bit per element |

## Verification
Inputs change 1 ns after the rising clk edge, and the outputs are checked twice in every clock period. The first check falls 3.5 ns after that rising edge. By then the falling-edge capture has happened, but the next rising edge has not. So this check separates immediate from edge-timed set/reset and true from inverted clock polarity. The second check falls 0.5 ns after the next rising edge. By then every mode must have reached its next state. gsr and an immediate set/reset must already show at the first check, and an edge-timed result that waits for the rising clk edge is expected only at the second. The reference model sweeps all 32 site-bit combinations, with random per-element bits and random data, enable and set/reset traffic.

// File: rtl/slice_bank_pkg.sv
`timescale 1ns/1ps
package slice_bank_pkg;

  // number of site-wide configuration bits at the bottom of the word
  localparam int SITE_W = 5;

  // site bits, packed so that bit 0 is the timing-style bit
  typedef struct packed {
    logic sr_use;      // cfg[4]
    logic ce_use;      // cfg[3]
    logic clk_inv;     // cfg[2]
    logic latch_mode;  // cfg[1]
    logic sync_sr;     // cfg[0]
  } site_cfg_t;

  // value loaded by set/reset: class 0 stores inverted sense
  function automatic logic rst_load(input logic set_class, input logic bitv);
    return set_class ? bitv : ~bitv;
  endfunction

  // value loaded by global init: inverted sense in flip-flop mode
  function automatic logic init_load(input logic latch_on, input logic bitv);
    return latch_on ? bitv : ~bitv;
  endfunction

endpackage

// File: rtl/slice_cfg_decode.sv
`timescale 1ns/1ps
module slice_cfg_decode
  import slice_bank_pkg::*;
#(
  parameter  int N_PRI = 4,
  localparam int N_EL  = 2 * N_PRI,
  localparam int CFG_W = SITE_W + 3 * N_EL
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             sr,
  input  logic [CFG_W-1:0] cfg,
  output logic             latch_mode,
  output logic             gate,
  output logic             ce_eff,
  output logic             sr_sync,
  output logic             sr_async,
  output logic             sr_level,
  output logic [N_EL-1:0]  rst_v,
  output logic [N_EL-1:0]  init_v
);

  localparam int KIND_LO = SITE_W;
  localparam int RBIT_LO = SITE_W + N_EL;
  localparam int IBIT_LO = SITE_W + 2 * N_EL;

  site_cfg_t site;
  logic      sr_req;

  assign site = site_cfg_t'(cfg[SITE_W-1:0]);

  // R8: effective polarity folds the latch bit into the invert bit
  assign gate       = clk ^ (site.clk_inv ^ site.latch_mode);
  assign latch_mode = site.latch_mode;

  // R6: unused enable is tied active
  assign ce_eff = site.ce_use ? ce : 1'b1;

  // R7 / R1: set/reset gated by its use bit, then split by timing style
  assign sr_req   = site.sr_use & sr;
  assign sr_sync  = sr_req & site.sync_sr;
  assign sr_async = sr_req & ~site.sync_sr;
  assign sr_level = sr_req;

  // R4 / R5: per-element load values
  for (genvar i = 0; i < N_EL; i++) begin : g_vals
    assign rst_v[i]  = rst_load(cfg[KIND_LO+i], cfg[RBIT_LO+i]);
    assign init_v[i] = init_load(site.latch_mode, cfg[IBIT_LO+i]);
  end

endmodule

// File: rtl/slice_ff_cell.sv
`timescale 1ns/1ps
module slice_ff_cell (
  input  logic gate,
  input  logic gsr,
  input  logic init_v,
  input  logic rst_v,
  input  logic sr_sync,
  input  logic sr_async,
  input  logic ce_eff,
  input  logic d,
  output logic q
);

  logic q_nxt;

  // next-state: edge-timed set/reset beats the enable (R9)
  always_comb begin
    if (sr_sync) begin
      q_nxt = rst_v;
    end else if (ce_eff) begin
      q_nxt = d;
    end else begin
      q_nxt = q;
    end
  end

  // register: global init first, then immediate set/reset (R1, R5)
  always_ff @(posedge gate or posedge gsr or posedge sr_async) begin
    if (gsr) begin
      q <= init_v;
    end else if (sr_async) begin
      q <= rst_v;
    end else begin
      q <= q_nxt;
    end
  end

  // R1
  sr_sync_load_chk: assert property (@(posedge gate) disable iff (gsr)
    sr_sync |=> (q == $past(rst_v)));

  // R6
  ce_hold_chk: assert property (@(posedge gate) disable iff (gsr)
    (!ce_eff && !sr_sync && !sr_async) |=> (sr_async || $stable(q)));

  // R9
  ce_capture_chk: assert property (@(posedge gate) disable iff (gsr)
    (ce_eff && !sr_sync && !sr_async) |=> (sr_async || q == $past(d)));

endmodule

// File: rtl/slice_latch_cell.sv
`timescale 1ns/1ps
module slice_latch_cell (
  input  logic gate,
  input  logic gsr,
  input  logic init_v,
  input  logic rst_v,
  input  logic sr_level,
  input  logic ce_eff,
  input  logic d,
  output logic q
);

  logic open_w;

  // R2: transparent while the gate is high and the enable is active
  assign open_w = gate & ce_eff;

  always_latch begin
    if (gsr) begin
      q <= init_v;
    end else if (sr_level) begin
      q <= rst_v;
    end else if (open_w) begin
      q <= d;
    end
  end

endmodule

// File: rtl/slice_store_bank.sv
`timescale 1ns/1ps
module slice_store_bank
  import slice_bank_pkg::*;
#(
  parameter  int N_PRI = 4,
  localparam int N_EL  = 2 * N_PRI,
  localparam int CFG_W = SITE_W + 3 * N_EL
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             sr,
  input  logic             gsr,
  input  logic [N_EL-1:0]  d,
  input  logic [CFG_W-1:0] cfg,
  output logic [N_EL-1:0]  q
);

  logic            latch_mode;
  logic            gate;
  logic            ce_eff;
  logic            sr_sync;
  logic            sr_async;
  logic            sr_level;
  logic [N_EL-1:0] rst_v;
  logic [N_EL-1:0] init_v;
  logic [N_EL-1:0] ff_q;

  slice_cfg_decode #(.N_PRI(N_PRI)) u_decode (
    .clk        (clk),
    .ce         (ce),
    .sr         (sr),
    .cfg        (cfg),
    .latch_mode (latch_mode),
    .gate       (gate),
    .ce_eff     (ce_eff),
    .sr_sync    (sr_sync),
    .sr_async   (sr_async),
    .sr_level   (sr_level),
    .rst_v      (rst_v),
    .init_v     (init_v)
  );

  for (genvar i = 0; i < N_EL; i++) begin : g_el
    slice_ff_cell u_ff (
      .gate     (gate),
      .gsr      (gsr),
      .init_v   (init_v[i]),
      .rst_v    (rst_v[i]),
      .sr_sync  (sr_sync),
      .sr_async (sr_async),
      .ce_eff   (ce_eff),
      .d        (d[i]),
      .q        (ff_q[i])
    );

    if (i < N_PRI) begin : g_pri
      logic lat_q;

      slice_latch_cell u_lat (
        .gate     (gate),
        .gsr      (gsr),
        .init_v   (init_v[i]),
        .rst_v    (rst_v[i]),
        .sr_level (sr_level),
        .ce_eff   (ce_eff),
        .d        (d[i]),
        .q        (lat_q)
      );

      // R2: primary row switches to the latch in latch mode
      assign q[i] = latch_mode ? lat_q : ff_q[i];
    end else begin : g_sec
      // R3: secondary row parked at its init value in latch mode
      assign q[i] = latch_mode ? init_v[i] : ff_q[i];
    end
  end

  // R3
  sec_idle_chk: assert property (@(posedge clk) disable iff (gsr)
    (latch_mode && $stable(cfg)) |-> $stable(q[N_EL-1:N_PRI]));

endmodule

// File: tb/slice_store_bank_bench.sv
`timescale 1ns/1ps
module slice_store_bank_bench;

  localparam int NP = 4;
  localparam int N  = 2 * NP;
  localparam int CW = 5 + 3 * N;

  logic          clk = 1'b0;
  logic          ce, sr, gsr;
  logic [N-1:0]  d;
  logic [CW-1:0] cfg;
  logic [N-1:0]  q;

  int errs   = 0;
  int checks = 0;
  bit done   = 0;
  logic [N-1:0] st;

  always #2.5 clk = ~clk;

  slice_store_bank u_slice_store_bank (
    .clk (clk), .ce (ce), .sr (sr), .gsr (gsr), .d (d), .cfg (cfg), .q (q)
  );

  function automatic logic [N-1:0] init_of(input logic [CW-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = c[1] ? c[21+i] : ~c[21+i];
    return r;
  endfunction

  function automatic logic [N-1:0] rst_of(input logic [CW-1:0] c);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = c[5+i] ? c[13+i] : ~c[13+i];
    return r;
  endfunction

  // latch mode hides the secondary row behind its init value
  function automatic logic [N-1:0] shown(input logic [CW-1:0] c, input logic [N-1:0] v);
    logic [N-1:0] r;
    r = v;
    if (c[1]) r[N-1:NP] = init_of(c) >> NP;
    return r;
  endfunction

  task automatic check(input logic [N-1:0] exp, input string tag);
    checks++;
    if (q !== exp) begin
      errs++;
      $display("FAIL %s: q=%b expected %b at %0t", tag, q, exp, $time);
    end
  endtask

  // entered 0.5 ns after a rising clk edge, leaves 0.5 ns after the next
  task automatic cycle(input logic [CW-1:0] c, input logic ce_i, input logic sr_i,
                       input logic gsr_i, input logic [N-1:0] d_i, input bit chk);
    logic [N-1:0] nxt, mid;
    logic srh;
    string tag;
    #0.5;
    cfg = c; ce = ce_i; sr = sr_i; gsr = gsr_i; d = d_i;
    srh = c[4] & sr_i;
    if (gsr_i)                 nxt = init_of(c);
    else if (srh)              nxt = rst_of(c);
    else if (!c[3] || ce_i)    nxt = d_i;
    else                       nxt = st;
    if (gsr_i)                 mid = init_of(c);
    else if (c[1])             mid = nxt;
    else if (srh && !c[0])     mid = rst_of(c);
    else if (c[2])             mid = nxt;
    else                       mid = st;
    if (gsr_i)            tag = "R5 R9 global init";
    else if (srh)         tag = "R1 R4 R9 set/reset";
    else if (sr_i)        tag = "R7 unused set/reset";
    else if (!c[3])       tag = "R6 enable tied";
    else if (c[1])        tag = "R2 R8 latch";
    else                  tag = "R6 R8 capture";
    if (c[1]) tag = {tag, " R3"};
    #2.5;
    if (chk) check(shown(c, mid), {tag, " mid-cycle"});
    #2.0;
    if (chk) check(shown(c, nxt), {tag, " end-cycle"});
    st = nxt;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] c;
    bit pg;
    cfg = '0; ce = 1'b0; sr = 1'b0; gsr = 1'b1; d = '0;
    st  = '0;
    @(posedge clk);
    #0.5;
    cycle('0, 1'b0, 1'b0, 1'b1, '0, 1'b0);
    // R5 reset state: flip-flop mode, init bits 0 -> all ones
    cycle('0, 1'b0, 1'b0, 1'b1, '0, 1'b1);
    checks++;
    if (q !== {N{1'b1}}) begin
      errs++;
      $display("FAIL R5 reset state: q=%b expected %b", q, {N{1'b1}});
    end

    for (int s = 0; s < 32; s++) begin
      c = {$urandom(), s[4:0]};
      // configuration changes only under global init
      cycle(c, 1'b0, 1'b0, 1'b1, '0, 1'b0);
      cycle(c, 1'b0, 1'b0, 1'b1, '0, 1'b1);
      pg = 1'b1;
      for (int k = 0; k < 150; k++) begin
        logic g_i, s_i, e_i;
        g_i = ($urandom_range(0, 31) == 0);
        s_i = ($urandom_range(0, 99) < 18) && !g_i && !pg;
        e_i = ($urandom_range(0, 99) < 70);
        cycle(c, e_i, s_i, g_i, N'($urandom()), 1'b1);
        pg = g_i;
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule